// File: doc/BRIEF.md
# Programmable Label Match Filter

This block sits behind the serial decoder of one receive channel and decides which decoded 32-bit words are passed to the receive buffer. It holds a small memory of sixteen 8-bit labels. When recognition is switched on, a word is passed on only if its low byte equals one of the stored labels. Words that match nothing vanish without any indication. When recognition is off, every word is passed on.

The host fills the memory and reads it back through its ordinary write and read strobes. A 0-to-1 edge of the program-mode bit opens a session and sets both the write and the read position to location 0. While the mode bit stays high, the first sixteen qualified write strobes fill locations 0 to 15 in turn from the 8-bit host bus. The first sixteen qualified read strobes return locations 0 to 15 in turn. A strobe is qualified only when the half-select is high.

Reception is suspended for the whole time the mode bit is high. The candidate-word input uses valid/ready. `in_ready_o` is low while programming, and a word offered then is dropped rather than held. The output stream has no back-pressure: the buffer behind it must take every `out_valid_o` pulse.

Top module: `label_filter`

## Requirements
- R1: After reset, `out_valid_o` and `rd_valid_o` are 0, and `in_ready_o` is 1 when `mode_i` is 0.
- R2: After a 0-to-1 edge of `mode_i` (sampled on a clock edge), each cycle in a later clock cycle with `mode_i`, `host_wr_i` and `half_sel_i` all high writes `host_data_i` into the next label location. The locations are filled in order from 0 to 15.
- R3: In the same session, each qualified read cycle (`mode_i`, `host_rd_i` and `half_sel_i` all high) returns the next location, from 0 to 15. The value appears on `rd_data_o` with `rd_valid_o` high for one cycle, in the cycle after the strobe.
- R4: A write or read strobe with `half_sel_i` low has no effect. It stores nothing, returns nothing and does not advance the location.
- R5: `in_ready_o` is 0 while `mode_i` is 1. A word offered while `in_ready_o` is 0 never produces an output pulse.
- R6: When `recog_en_i` is 1, an accepted word (`word_valid_i` and `in_ready_o` both high) whose bits 7:0 equal any stored label is passed on. `out_valid_o` is high for one cycle with `out_word_o` equal to the word, in the cycle after it was offered. Bus bit k of a label is compared with word bit k.
- R7: When `recog_en_i` is 1, a word whose bits 7:0 match no stored label produces no output pulse.
- R8: A stored label of 8'h00 matches a word with bits 7:0 equal to 8'h00, like any other value.
- R9: When `recog_en_i` is 0, every accepted word is passed on as in R6, whatever its label.
- R10: Once sixteen writes (or sixteen reads) have been taken in a session, further writes (or reads) are ignored until `mode_i` returns to 0. A new 0-to-1 edge restarts both positions at location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Program mode; a 0-to-1 edge opens a load/readback session |
| recog_en_i | input | 1 | Label recognition enable |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_rd_i | input | 1 | Host read strobe, one cycle per access |
| half_sel_i | input | 1 | Half-select; must be 1 for label accesses |
| host_data_i | input | 8 | Label value to be written |
| rd_data_o | output | 8 | Label value read back |
| rd_valid_o | output | 1 | Readback data valid for one cycle |
| word_valid_i | input | 1 | Candidate word valid |
| word_i | input | 32 | Candidate word; bits 7:0 are the label |
| in_ready_o | output | 1 | Block takes candidate words (0 while programming) |
| out_valid_o | output | 1 | Passed-on word valid for one cycle |
| out_word_o | output | 32 | Passed-on word |

## Verification
A wrong write position or a counter that wraps past 16 corrupts a label location. The readback shows this within one cycle of the affected read strobe, as a value out of order or an extra `rd_valid_o` pulse. A corrupted or wrongly compared location shows up in the cycle after the first word carrying that label is offered. The result is either a missing `out_valid_o` or a pulse that should not occur. A suspension that releases too early shows up as an output pulse one cycle after a word offered during programming.

// File: rtl/label_pkg.sv
package label_pkg;
  localparam int LBL_W  = 8;
  localparam int DEPTH  = 16;
  localparam int WORD_W = 32;
  typedef logic [LBL_W-1:0] label_t;
endpackage

// File: rtl/label_store.sv
module label_store
  import label_pkg::*;
#(
  parameter int N = DEPTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sess_start,
  input  logic            sess_on,
  input  logic            wr_stb,
  input  logic            rd_stb,
  input  label_t          wr_data,
  output label_t          rd_data,
  output logic            rd_valid,
  output label_t          labels [N]
);
  localparam int CNT_W = $clog2(N) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N);

  logic [CNT_W-1:0] wr_pos, rd_pos;
  logic             wr_take, rd_take;

  assign wr_take = sess_on && wr_stb && (wr_pos < LAST);
  assign rd_take = sess_on && rd_stb && (rd_pos < LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pos <= '0;
      rd_pos <= '0;
    end else if (sess_start) begin
      wr_pos <= '0;
      rd_pos <= '0;
    end else begin
      if (wr_take) wr_pos <= wr_pos + 1'b1;
      if (rd_take) rd_pos <= rd_pos + 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_loc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        labels[g] <= '0;
      else if (wr_take && (wr_pos == CNT_W'(g)))
        labels[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_take;
      if (rd_take) rd_data <= labels[rd_pos[CNT_W-2:0]];
    end
  end
endmodule

// File: rtl/label_match.sv
module label_match
  import label_pkg::*;
#(
  parameter int N = DEPTH
) (
  input  label_t labels [N],
  input  label_t probe,
  output logic   hit
);
  logic [N-1:0] eq;
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = (labels[g] == probe);
  end
  assign hit = |eq;
endmodule

// File: rtl/label_filter.sv
module label_filter
  import label_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              recog_en_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic              half_sel_i,
  input  logic [LBL_W-1:0]  host_data_i,
  output logic [LBL_W-1:0]  rd_data_o,
  output logic              rd_valid_o,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_word_o
);
  logic   mode_q, sess_start, sess_on, hit, accept;
  label_t labels [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_i;
  end

  assign sess_start = mode_i && !mode_q;
  assign sess_on    = mode_i && mode_q;
  assign in_ready_o = !mode_i;

  label_store #(.N(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .sess_start (sess_start),
    .sess_on    (sess_on),
    .wr_stb     (host_wr_i && half_sel_i),
    .rd_stb     (host_rd_i && half_sel_i),
    .wr_data    (host_data_i),
    .rd_data    (rd_data_o),
    .rd_valid   (rd_valid_o),
    .labels     (labels)
  );

  label_match #(.N(DEPTH)) u_match (
    .labels (labels),
    .probe  (word_i[LBL_W-1:0]),
    .hit    (hit)
  );

  assign accept = word_valid_i && in_ready_o && (!recog_en_i || hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_word_o  <= '0;
    end else begin
      out_valid_o <= accept;
      if (accept) out_word_o <= word_i;
    end
  end
endmodule

// File: rtl/label_filter_chk.sv
module label_filter_chk
  import label_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_i,
  input logic              recog_en_i,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic              half_sel_i,
  input logic [LBL_W-1:0]  host_data_i,
  input logic [LBL_W-1:0]  rd_data_o,
  input logic              rd_valid_o,
  input logic              word_valid_i,
  input logic [WORD_W-1:0] word_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [WORD_W-1:0] out_word_o
);
  assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_i && mode_i) |=> !out_valid_o);
  assert_out_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ($past(word_valid_i) && out_word_o == $past(word_i)));
  assert_pass_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_i && in_ready_o && !recog_en_i) |=> out_valid_o);
  assert_rd_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(host_rd_i && half_sel_i && mode_i));
  assert_half_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && !half_sel_i) |=> !rd_valid_o);
endmodule

bind label_filter label_filter_chk u_chk (.*);

// File: tb/test_label_filter.sv
module test_label_filter;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        mode_i = 0, recog_en_i = 0, host_wr_i = 0, host_rd_i = 0, half_sel_i = 0;
  logic [7:0]  host_data_i = '0;
  logic [7:0]  rd_data_o;
  logic        rd_valid_o, word_valid_i = 0, in_ready_o, out_valid_o;
  logic [31:0] word_i = '0, out_word_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_w [$];
  logic [7:0]  exp_r [$];
  logic [7:0]  lbl [16];
  bit          done = 0;

  always #2 clk = ~clk;

  label_filter i_label_filter (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (out_valid_o) begin
      if (exp_w.size() == 0) chk(0, "R7/R5 unexpected word", out_word_o, 32'hx);
      else begin
        logic [31:0] e;
        e = exp_w.pop_front();
        chk(out_word_o == e, "R6 word", out_word_o, e);
      end
    end
    if (rd_valid_o) begin
      if (exp_r.size() == 0) chk(0, "R10/R4 unexpected read", {24'h0, rd_data_o}, 32'hx);
      else begin
        logic [7:0] e;
        e = exp_r.pop_front();
        chk(rd_data_o == e, "R3 readback", {24'h0, rd_data_o}, {24'h0, e});
      end
    end
  end

  task automatic send(logic [31:0] w, bit pass);
    @(negedge clk);
    word_valid_i = 1; word_i = w;
    if (pass) exp_w.push_back(w);
    @(negedge clk);
    word_valid_i = 0;
  endtask

  task automatic hwr(logic [7:0] d, bit hs);
    @(negedge clk);
    host_wr_i = 1; half_sel_i = hs; host_data_i = d;
    @(negedge clk);
    host_wr_i = 0; half_sel_i = 0;
  endtask

  task automatic hrd(bit hs, bit expect_data, logic [7:0] e);
    @(negedge clk);
    host_rd_i = 1; half_sel_i = hs;
    if (expect_data) exp_r.push_back(e);
    @(negedge clk);
    host_rd_i = 0; half_sel_i = 0;
  endtask

  task automatic enter_mode();
    @(negedge clk); mode_i = 1;
    @(negedge clk);
  endtask

  task automatic drain(string req);
    repeat (3) @(negedge clk);
    chk(exp_w.size() == 0 && exp_r.size() == 0, req,
        32'(exp_w.size() + exp_r.size()), 0);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid_o && !rd_valid_o && in_ready_o, "R1 reset",
        {29'h0, out_valid_o, rd_valid_o, in_ready_o}, 32'h1);

    for (int i = 0; i < 16; i++) lbl[i] = 8'h10 + 8'(i * 7);
    lbl[5] = 8'h00;

    enter_mode();
    chk(!in_ready_o, "R5 ready low", {31'h0, in_ready_o}, 0);
    send(32'hABCD_0000, 0);
    for (int i = 0; i < 16; i++) begin
      if (i == 3) hwr(8'hEE, 0);      // R4 ignored write
      hwr(lbl[i], 1);                 // R2 ordered load
    end
    hwr(8'hFF, 1);                    // R10 17th write ignored
    hrd(0, 0, 0);                     // R4 ignored read
    for (int i = 0; i < 16; i++) hrd(1, 1, lbl[i]);
    hrd(1, 0, 0);                     // R10 17th read ignored
    drain("R2 R3 R4 R10 queues empty");

    @(negedge clk); mode_i = 0; recog_en_i = 1;
    @(negedge clk);
    chk(in_ready_o, "R5 ready back", {31'h0, in_ready_o}, 1);
    send({24'h123456, lbl[0]}, 1);    // R6
    send({24'h0000AA, lbl[15]}, 1);   // R6
    send(32'h5555_55EE, 0);           // R7 (EE was not stored)
    send(32'h0000_00FF, 0);           // R7 R10 (FF was not stored)
    send(32'h8765_4300, 1);           // R8 zero label
    send({24'hC0FFEE, lbl[9]}, 1);    // R6
    drain("R6 R7 R8 results");

    @(negedge clk); recog_en_i = 0;
    send(32'h5555_55EE, 1);           // R9
    send(32'hFFFF_FFFF, 1);           // R9
    drain("R9 pass all");

    enter_mode();                     // R10 re-entry restarts at 0
    for (int i = 0; i < 16; i++) hwr(8'hA0 + 8'(i), 1);
    for (int i = 0; i < 3; i++) hrd(1, 1, 8'hA0 + 8'(i));
    drain("R10 restart");
    @(negedge clk); mode_i = 0; recog_en_i = 1;
    send(32'h0000_0000, 0);           // R8 zero no longer stored
    send(32'h0000_00AF, 1);           // R6 last new label
    drain("R10 new labels in use");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule